// File: doc/BRIEF.md
# MPR Read-Calibration Command Sequencer

This block belongs to the command path of a DDR3 memory controller. When the controller wants to train its read capture, it pulses `start`. The block then drives the command, bank and address buses through a fixed sequence:

1. Close every bank.
2. Switch the device's multipurpose register (MPR) on through mode register 3.
3. Read the predefined pattern twice with a chopped burst of four beats. The first read returns the low nibble and the second returns the high nibble.
4. Switch the MPR off again.

A one-cycle `done` pulse tells the controller that normal commands may resume. Capturing the returned data is the job of other logic.

Each gap between two commands is held at its minimum legal spacing. A separate down-counter enforces each gap:

- precharge period;
- mode-register-set delay, used after both mode-register writes;
- read-to-read spacing;
- data drain plus MPR recovery after the second read.

Every spacing is a parameter counted in clock cycles. On every cycle with nothing else to issue, the block drives a deselect-free NOP. All bus outputs are registered.

Top module: `mpr_rdcal_seq`

## Requirements
- R1: During and after synchronous reset, and while idle, the outputs are `cmd_n` = 4'b0111 (NOP), `bank` = 0, `addr` = 0 and `done` = 0. `cmd_n` is {CS#, RAS#, CAS#, WE#}.
- R2: If `start` is sampled high while idle, the next cycle shows a precharge-all: `cmd_n` = 4'b0010, `addr` bit 10 = 1, all other `addr` bits 0, `bank` = 0.
- R3: Exactly T_RP cycles after the precharge, a mode-register-set appears with `cmd_n` = 4'b0000, `bank` = 3 and only `addr` bit 2 set (MPR on).
- R4: Exactly T_MOD cycles after the MPR-on write, a read appears with `cmd_n` = 4'b0101, `bank` = 0 and `addr` = 0. This means bit 2 = 0 (low nibble), bits 1:0 = 0, bit 10 = 0 (no auto-precharge) and bit 12 = 0 (4-beat chop).
- R5: Exactly T_CCD cycles after the first read, a second read appears with `cmd_n` = 4'b0101, `bank` = 0 and only `addr` bit 2 set (high nibble, chop on).
- R6: Exactly RD_LAT + 2 + T_MPRR cycles after the second read, a mode-register-set appears with `cmd_n` = 4'b0000, `bank` = 3 and `addr` = 0 (MPR off).
- R7: Exactly T_MOD cycles after the MPR-off write, `done` is high for exactly one cycle while the bus shows NOP.
- R8: Every cycle of a sequence that carries none of the five commands shows NOP with `bank` and `addr` at 0.
- R9: A `start` pulse that arrives while a sequence runs is ignored. The running sequence keeps its timing, and no extra precharge appears.
- R10: A `start` sampled in the cycle where `done` is high begins a new sequence, with its precharge in the next cycle.
- R11: Reset applied in the middle of a sequence forces NOP at once. After release the block stays idle, and no `done` appears until a new `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a calibration sequence (honoured only when idle) |
| cmd_n | output | 4 | Registered command {CS#, RAS#, CAS#, WE#} |
| bank | output | BA_W | Registered bank address |
| addr | output | ADDR_W | Registered row/column address |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench builds the block with T_RP = 3, T_MOD = 7, T_CCD = 2, RD_LAT = 5 and T_MPRR = 3. Every spacing is therefore distinct and short, so a swapped or off-by-one counter shifts a command onto a cycle where the bench expects NOP. The short read latency puts a whole sequence inside 30 cycles. That leaves room to run several complete sequences cycle by cycle:

- with stray `start` pulses during two different wait phases;
- back-to-back from the `done` cycle;
- after a reset that cuts a sequence off between its reads.

// File: rtl/mpr_cal_pkg.sv
package mpr_cal_pkg;

  // Command encodings, {CS#, RAS#, CAS#, WE#}
  localparam logic [3:0] CMD_NOP  = 4'b0111;
  localparam logic [3:0] CMD_READ = 4'b0101;
  localparam logic [3:0] CMD_PRE  = 4'b0010;
  localparam logic [3:0] CMD_MRS  = 4'b0000;

  // Address bit positions the device decodes
  localparam int BIT_MPR_SEL = 2;   // MPR enable on MRS, nibble select on read
  localparam int BIT_AP      = 10;  // all-bank precharge / auto-precharge
  localparam int BIT_BC_N    = 12;  // burst chop, active low

  localparam int MR3_BANK = 3;

  typedef enum logic [2:0] {
    OP_NOP,
    OP_PREA,
    OP_MRS_ON,
    OP_RD_LO,
    OP_RD_HI,
    OP_MRS_OFF
  } mpr_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_W_RP,
    ST_W_MOD_ON,
    ST_W_CCD,
    ST_W_DRAIN,
    ST_W_MOD_OFF
  } mpr_state_e;

endpackage

// File: rtl/mpr_wait_timer.sv
module mpr_wait_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] RELOAD = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= RELOAD;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R8
  reload_after_expiry_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> (cnt_q == '0));

  // R8
  counts_down_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/mpr_seq_ctrl.sv
module mpr_seq_ctrl
  import mpr_cal_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    rp_exp,
  input  logic    mod_exp,
  input  logic    ccd_exp,
  input  logic    drain_exp,
  output mpr_op_e op,
  output logic    ld_rp,
  output logic    ld_mod,
  output logic    ld_ccd,
  output logic    ld_drain,
  output logic    fin
);
  mpr_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    op       = OP_NOP;
    ld_rp    = 1'b0;
    ld_mod   = 1'b0;
    ld_ccd   = 1'b0;
    ld_drain = 1'b0;
    fin      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        op      = OP_PREA;
        ld_rp   = 1'b1;
        state_d = ST_W_RP;
      end
      ST_W_RP: if (rp_exp) begin
        op      = OP_MRS_ON;
        ld_mod  = 1'b1;
        state_d = ST_W_MOD_ON;
      end
      ST_W_MOD_ON: if (mod_exp) begin
        op      = OP_RD_LO;
        ld_ccd  = 1'b1;
        state_d = ST_W_CCD;
      end
      ST_W_CCD: if (ccd_exp) begin
        op       = OP_RD_HI;
        ld_drain = 1'b1;
        state_d  = ST_W_DRAIN;
      end
      ST_W_DRAIN: if (drain_exp) begin
        op      = OP_MRS_OFF;
        ld_mod  = 1'b1;
        state_d = ST_W_MOD_OFF;
      end
      ST_W_MOD_OFF: if (mod_exp) begin
        fin     = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |-> (op != OP_PREA));

  // R7
  fin_only_after_exit_chk: assert property (@(posedge clk) disable iff (rst)
    fin |-> (state_q == ST_W_MOD_OFF));

endmodule

// File: rtl/mpr_cmd_build.sv
module mpr_cmd_build
  import mpr_cal_pkg::*;
#(
  parameter int BA_W   = 3,
  parameter int ADDR_W = 16
) (
  input  mpr_op_e           op,
  output logic [3:0]        cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    cmd  = CMD_NOP;
    ba   = '0;
    addr = '0;
    unique case (op)
      OP_PREA: begin
        cmd          = CMD_PRE;
        addr[BIT_AP] = 1'b1;
      end
      OP_MRS_ON: begin
        cmd               = CMD_MRS;
        ba                = BA_W'(MR3_BANK);
        addr[BIT_MPR_SEL] = 1'b1;
      end
      OP_MRS_OFF: begin
        cmd = CMD_MRS;
        ba  = BA_W'(MR3_BANK);
      end
      OP_RD_LO: begin
        cmd            = CMD_READ;
        addr[BIT_BC_N] = 1'b0;  // chop to four beats
      end
      OP_RD_HI: begin
        cmd               = CMD_READ;
        addr[BIT_BC_N]    = 1'b0;
        addr[BIT_MPR_SEL] = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mpr_rdcal_seq.sv
module mpr_rdcal_seq
  import mpr_cal_pkg::*;
#(
  parameter int BA_W   = 3,
  parameter int ADDR_W = 16,   // must be at least 13
  parameter int T_RP   = 6,
  parameter int T_MOD  = 12,
  parameter int T_CCD  = 4,
  parameter int RD_LAT = 11,
  parameter int T_MPRR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [3:0]        cmd_n,
  output logic [BA_W-1:0]   bank,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);
  localparam int BC4_CYC = 2;
  localparam int T_DRAIN = RD_LAT + BC4_CYC + T_MPRR;

  mpr_op_e           op;
  logic              ld_rp, ld_mod, ld_ccd, ld_drain, fin;
  logic              rp_exp, mod_exp, ccd_exp, drain_exp;
  logic [3:0]        cmd_d;
  logic [BA_W-1:0]   ba_d;
  logic [ADDR_W-1:0] addr_d;

  mpr_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .rp_exp(rp_exp), .mod_exp(mod_exp), .ccd_exp(ccd_exp), .drain_exp(drain_exp),
    .op(op), .ld_rp(ld_rp), .ld_mod(ld_mod), .ld_ccd(ld_ccd), .ld_drain(ld_drain),
    .fin(fin)
  );

  mpr_wait_timer #(.LIMIT(T_RP))    u_t_rp    (.clk(clk), .rst(rst), .load(ld_rp),    .expired(rp_exp));
  mpr_wait_timer #(.LIMIT(T_MOD))   u_t_mod   (.clk(clk), .rst(rst), .load(ld_mod),   .expired(mod_exp));
  mpr_wait_timer #(.LIMIT(T_CCD))   u_t_ccd   (.clk(clk), .rst(rst), .load(ld_ccd),   .expired(ccd_exp));
  mpr_wait_timer #(.LIMIT(T_DRAIN)) u_t_drain (.clk(clk), .rst(rst), .load(ld_drain), .expired(drain_exp));

  mpr_cmd_build #(.BA_W(BA_W), .ADDR_W(ADDR_W)) u_build (
    .op(op), .cmd(cmd_d), .ba(ba_d), .addr(addr_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_n <= CMD_NOP;
      bank  <= '0;
      addr  <= '0;
      done  <= 1'b0;
    end else begin
      cmd_n <= cmd_d;
      bank  <= ba_d;
      addr  <= addr_d;
      done  <= fin;
    end
  end

  // R7
  done_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  mrs_targets_mr3_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_n == CMD_MRS) |-> (bank == BA_W'(MR3_BANK)));

  // R4
  read_chop_low_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_n == CMD_READ) |-> (addr[BIT_BC_N] == 1'b0 && addr[1:0] == 2'b00 && addr[BIT_AP] == 1'b0));

  // R2
  pre_all_banks_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_n == CMD_PRE) |-> addr[BIT_AP]);

  // R11
  reset_to_nop_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cmd_n == CMD_NOP && !done));

  // R8
  nop_bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_n == CMD_NOP) |-> (bank == '0 && addr == '0));

endmodule

// File: tb/sim_mpr_rdcal_seq.sv
module sim_mpr_rdcal_seq;
  localparam int CLK_PER = 10;
  localparam int BA_W = 3, ADDR_W = 16;
  localparam int T_RP = 3, T_MOD = 7, T_CCD = 2, RD_LAT = 5, T_MPRR = 3;
  localparam int AT_ON   = T_RP;
  localparam int AT_RLO  = AT_ON + T_MOD;
  localparam int AT_RHI  = AT_RLO + T_CCD;
  localparam int AT_OFF  = AT_RHI + RD_LAT + 2 + T_MPRR;
  localparam int AT_DONE = AT_OFF + T_MOD;

  logic clk = 0, rst = 1, start = 0;
  logic [3:0] cmd_n;
  logic [BA_W-1:0] bank;
  logic [ADDR_W-1:0] addr;
  logic done;
  int vecs = 0, errs = 0;
  bit finished = 0;

  always #(CLK_PER/2) clk = ~clk;

  mpr_rdcal_seq #(.BA_W(BA_W), .ADDR_W(ADDR_W), .T_RP(T_RP), .T_MOD(T_MOD),
    .T_CCD(T_CCD), .RD_LAT(RD_LAT), .T_MPRR(T_MPRR)) u0 (
    .clk(clk), .rst(rst), .start(start), .cmd_n(cmd_n), .bank(bank), .addr(addr), .done(done));

  function automatic logic [ADDR_W-1:0] bitv(input int b);
    return ADDR_W'(1) << b;
  endfunction

  task automatic chk(input string tag, input logic [3:0] ec, input logic [BA_W-1:0] eb,
                     input logic [ADDR_W-1:0] ea, input logic ed);
    vecs++;
    if (cmd_n !== ec || bank !== eb || addr !== ea || done !== ed) begin
      errs++;
      $display("FAIL %s: got cmd=%b ba=%0d addr=%h done=%b, expected cmd=%b ba=%0d addr=%h done=%b",
               tag, cmd_n, bank, addr, done, ec, eb, ea, ed);
    end
  endtask

  task automatic chk_nop(input string tag);
    chk(tag, 4'b0111, '0, '0, 1'b0);
  endtask

  // expectation for cycle k of a sequence (k = 0 is the precharge)
  task automatic chk_step(input int k);
    if (k == 0)            chk("R2 precharge-all",  4'b0010, '0, bitv(10), 1'b0);
    else if (k == AT_ON)   chk("R3 MPR on",         4'b0000, 3,  bitv(2),  1'b0);
    else if (k == AT_RLO)  chk("R4 read low",       4'b0101, '0, '0,       1'b0);
    else if (k == AT_RHI)  chk("R5 read high",      4'b0101, '0, bitv(2),  1'b0);
    else if (k == AT_OFF)  chk("R6 MPR off",        4'b0000, 3,  '0,       1'b0);
    else if (k == AT_DONE) chk("R7 done pulse",     4'b0111, '0, '0,       1'b1);
    else                   chk_nop("R8 gap NOP");
  endtask

  // pre: start already sampled at the preceding edge; busy_at: index of a stray start
  task automatic run_seq(input bit pre, input int busy_at, input bit chain);
    if (!pre) begin
      start = 1;
      @(negedge clk);
    end else @(negedge clk);
    start = 0;
    for (int k = 0; k <= AT_DONE; k++) begin
      chk_step(k);
      start = (k == busy_at) ? 1'b1 : 1'b0;
      if (k == AT_DONE) start = chain;
      if (k < AT_DONE) @(negedge clk);
    end
    if (!chain) begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        start = 0;
        chk_nop("R7 R1 idle after done");
      end
    end
  endtask

  task automatic t_reset;
    rst = 1;
    repeat (3) @(negedge clk);
    chk_nop("R1 in reset");
    rst = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk_nop("R1 idle");
    end
  endtask

  task automatic t_basic;
    run_seq(0, -1, 0);
  endtask

  task automatic t_busy_start;
    run_seq(0, 5, 0);          // R9: stray start during the MOD wait
    run_seq(0, AT_RHI + 2, 0); // R9: stray start during the drain wait
  endtask

  task automatic t_chain;
    run_seq(0, -1, 1);         // R10: start in the done cycle
    run_seq(1, -1, 0);
  endtask

  task automatic t_mid_reset;
    start = 1;
    @(negedge clk);
    start = 0;
    for (int k = 0; k <= AT_RLO; k++) begin
      chk_step(k);
      @(negedge clk);
    end
    rst = 1;
    @(negedge clk);
    chk_nop("R11 reset mid-sequence");
    @(negedge clk);
    rst = 0;
    for (int i = 0; i < AT_DONE + 4; i++) begin
      @(negedge clk);
      chk_nop("R11 stays idle after reset");
    end
    run_seq(0, -1, 0);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_busy_start();
    t_chain();
    t_mid_reset();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got timeout, expected completion");
    summary();
  end
endmodule